// File: doc/BRIEF.md
# Two-Channel IDE Bus-Master Register File

This block holds the host-visible control and status registers for the bus-master side of a two-channel IDE host controller. It also combines the two channels' drive interrupt requests into one level-sensitive host interrupt. The host reaches it through byte-wide reads and writes in a 16-byte I/O window, 8 bytes per channel. Both halves have the same layout: a command byte, a view of one mode register that both channels share, a status byte, a private timing byte, and a 32-bit descriptor-table base address.

The command register drives the start and direction controls of the DMA engine outside this block. That engine reports completion and error events back as one-cycle pulses, and these set sticky status bits which the host clears by writing ones. The shared mode register records which channels have an interrupt pending. The host may only change the per-channel block bits in it, and a blocked channel does not reach the host line. A read returns its data one cycle after the request, marked by a valid strobe.

Top module: `ide_bm_regs`

## Requirements
- R1: A synchronous active-high reset clears the command, status, mode, both timing and both address registers, and drives host_irq low. After reset, every offset reads 0x00.
- R2: Address bit 3 selects the channel: offsets 0–7 belong to channel 0 and offsets 8–15 to channel 1. A write to one channel's command, status or address bytes leaves the other channel's copies unchanged.
- R3: Offset 3 of each channel holds a separate 8-bit read/write timing register.
- R4: Offset 1 of either channel reads the same mode register, laid out as: bit 2 channel 0 pending, bit 3 channel 1 pending, bit 4 channel 0 block, bit 5 channel 1 block, all other bits 0.
- R5: A host write to the mode register loads bits 5:4 from the written data and leaves the pending bits unchanged.
- R6: Each pending bit follows its chan_irq input with one clock of delay, so a rising request sets the bit and a falling request clears it.
- R7: host_irq is high exactly when some channel has its pending bit set and its block bit clear. It updates on the same edge as the mode register.
- R8: A status write loads bits 6:5 from the data, keeps bit 0, clears bit 1 and bit 2 wherever the data bit is 1 (otherwise they hold), and leaves bits 7, 4 and 3 at 0.
- R9: A command write stores only bit 0 (start) and bit 3 (direction), and these drive dma_start and dma_dir. A 0→1 change of start sets status bit 0, and a 1→0 change clears it.
- R10: The address register takes byte writes at channel offsets 4–7, where offset 4 is the least significant byte. A read at offset 4 always returns bits 1:0 as 0.
- R11: chan_cfg reads 0x04, with 0x08 added when the SECOND_EN parameter is 1.
- R12: A dma_err pulse sets status bit 1 and a dma_done pulse sets status bit 2 of that channel. A set wins over a clear written in the same cycle.
- R13: rd_valid and rdata appear on the clock edge after the one that sampled rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| rd_en | input | 1 | Host byte read strobe |
| addr | input | 4 | Byte offset in the window |
| wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid |
| rdata | output | 8 | Registered read data |
| chan_irq | input | 2 | Per-channel drive interrupt request level |
| dma_err | input | 2 | Per-channel error event pulse |
| dma_done | input | 2 | Per-channel completion event pulse |
| dma_start | output | 2 | Per-channel start control |
| dma_dir | output | 2 | Per-channel direction control |
| host_irq | output | 1 | Combined host interrupt level |
| chan_cfg | output | 8 | Channel-enable configuration byte |

## Verification
The bench writes all ones to the mode register while a request is pending. A design that let the host write reach the pending bits would show a changed pending bit in the readback, or a wrong host_irq. Status is tested with a write that has zeros in the clear-on-one positions and with one that has ones there. A plain read/write status byte would return the data as written, and a design that cleared the sticky bits without regard to the data would lose bit 1 when only bit 2 is written. The bench toggles the block bits with exactly one channel pending, so a combiner that ignored the block, or applied the wrong channel's block, would show on host_irq. Timing and address bytes are written with different values on each channel, so any aliasing between the halves shows up on readback.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;
  localparam int         NUM_CH        = 2;
  localparam logic [2:0] OFF_CMD       = 3'd0;
  localparam logic [2:0] OFF_MODE      = 3'd1;
  localparam logic [2:0] OFF_STAT      = 3'd2;
  localparam logic [2:0] OFF_TIM       = 3'd3;
  localparam int         MODE_PEND_LSB = 2;
  localparam int         MODE_BLK_LSB  = 4;
  localparam logic [7:0] CMD_KEEP      = 8'h09;
  localparam logic [7:0] STAT_WR_MASK  = 8'h60;
  localparam logic [7:0] STAT_W1C_MASK = 8'h06;
  localparam logic [7:0] STAT_HOLD     = 8'h01;
  localparam logic [7:0] CFG_PRI       = 8'h04;
  localparam logic [7:0] CFG_SEC       = 8'h08;
endpackage

// File: rtl/ide_bm_chan.sv
module ide_bm_chan
  import ide_bm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] off,
  input  logic [7:0] wdata,
  input  logic       err_evt,
  input  logic       done_evt,
  output logic       start,
  output logic       dir,
  output logic [7:0] rd_byte
);
  localparam int NB    = ADDR_W / 8;
  localparam int BIX_W = $clog2(NB);

  logic [7:0]        cmd_q, cmd_d;
  logic [7:0]        stat_q, stat_d;
  logic [7:0]        tim_q;
  logic [ADDR_W-1:0] base_q;
  logic [BIX_W-1:0]  bix;

  assign bix = off[BIX_W-1:0];

  always_comb begin
    cmd_d = cmd_q;
    if (wr_en && off == OFF_CMD) cmd_d = wdata & CMD_KEEP;
    stat_d = stat_q;
    if (wr_en && off == OFF_STAT)
      stat_d = (wdata & STAT_WR_MASK) | (stat_q & STAT_HOLD) |
               (stat_q & ~wdata & STAT_W1C_MASK);
    if (cmd_d[0] && !cmd_q[0])      stat_d[0] = 1'b1;
    else if (!cmd_d[0] && cmd_q[0]) stat_d[0] = 1'b0;
    if (err_evt)  stat_d[1] = 1'b1;
    if (done_evt) stat_d[2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      stat_q <= '0;
      tim_q  <= '0;
      base_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      stat_q <= stat_d;
      if (wr_en && off == OFF_TIM) tim_q <= wdata;
      for (int b = 0; b < NB; b++)
        if (wr_en && off[2] && bix == BIX_W'(b)) base_q[8*b +: 8] <= wdata;
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    if (off[2]) begin
      rd_byte = base_q[8*bix +: 8];
      if (bix == '0) rd_byte[1:0] = 2'b00;
    end else begin
      case (off)
        OFF_CMD:  rd_byte = cmd_q;
        OFF_STAT: rd_byte = stat_q;
        OFF_TIM:  rd_byte = tim_q;
        default:  rd_byte = 8'h00;
      endcase
    end
  end

  assign start = cmd_q[0];
  assign dir   = cmd_q[3];

  // R9: start edges move the active bit on the same edge
  a_r9_active_set: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_q[0]) |-> stat_q[0]);
  a_r9_active_clr: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_q[0]) |-> !stat_q[0]);
  // R8: unused status positions stay zero
  a_r8_stat_zero: assert property (@(posedge clk) disable iff (rst)
    stat_q[7] == 1'b0 && stat_q[4:3] == 2'b00);
  // R12: an event pulse always lands in the status bit
  a_r12_err_sets: assert property (@(posedge clk) disable iff (rst)
    err_evt |=> stat_q[1]);
endmodule

// File: rtl/ide_bm_mode.sv
module ide_bm_mode
  import ide_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] blk_wdata,
  input  logic [NUM_CH-1:0] irq_in,
  output logic [7:0]        mode_byte,
  output logic              host_irq
);
  logic [NUM_CH-1:0] pend_q, blk_q, blk_d;
  logic              irq_q;

  assign blk_d = wr_en ? blk_wdata : blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      blk_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= irq_in;
      blk_q  <= blk_d;
      irq_q  <= |(irq_in & ~blk_d);
    end
  end

  always_comb begin
    mode_byte = 8'h00;
    mode_byte[MODE_PEND_LSB +: NUM_CH] = pend_q;
    mode_byte[MODE_BLK_LSB  +: NUM_CH] = blk_q;
  end

  assign host_irq = irq_q;

  // R6: pending follows the request with one clock of delay
  a_r6_pend_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pend_q == $past(irq_in));
  // R5: block bits move only on a host mode write
  a_r5_blk_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(blk_q));
  // R7: host line is the masked OR of pending bits
  a_r7_combine: assert property (@(posedge clk) disable iff (rst)
    host_irq == |(pend_q & ~blk_q));
endmodule

// File: rtl/ide_bm_regs.sv
module ide_bm_regs
  import ide_bm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter bit SECOND_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        addr,
  input  logic [7:0]        wdata,
  output logic              rd_valid,
  output logic [7:0]        rdata,
  input  logic [NUM_CH-1:0] chan_irq,
  input  logic [NUM_CH-1:0] dma_err,
  input  logic [NUM_CH-1:0] dma_done,
  output logic [NUM_CH-1:0] dma_start,
  output logic [NUM_CH-1:0] dma_dir,
  output logic              host_irq,
  output logic [7:0]        chan_cfg
);
  localparam logic [7:0] CFG_VAL = CFG_PRI | (SECOND_EN ? CFG_SEC : 8'h00);

  logic [2:0] off;
  logic       csel;
  logic [7:0] ch_rd [NUM_CH];
  logic [7:0] mode_byte;
  logic [7:0] rd_mux;
  logic       mode_wr;

  assign off     = addr[2:0];
  assign csel    = addr[3];
  assign mode_wr = wr_en && off == OFF_MODE;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_en && csel == 1'(c) && off != OFF_MODE;
    ide_bm_chan #(.ADDR_W(ADDR_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (ch_wr),
      .off      (off),
      .wdata    (wdata),
      .err_evt  (dma_err[c]),
      .done_evt (dma_done[c]),
      .start    (dma_start[c]),
      .dir      (dma_dir[c]),
      .rd_byte  (ch_rd[c])
    );
  end

  ide_bm_mode u_mode (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (mode_wr),
    .blk_wdata (wdata[MODE_BLK_LSB +: NUM_CH]),
    .irq_in    (chan_irq),
    .mode_byte (mode_byte),
    .host_irq  (host_irq)
  );

  assign rd_mux = (off == OFF_MODE) ? mode_byte : ch_rd[csel];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rdata    <= 8'h00;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  assign chan_cfg = CFG_VAL;

  // R13: read strobe answered on the next edge
  a_r13_rd_lat: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rd_valid == $past(rd_en));
endmodule

// File: tb/tb_ide_bm_regs.sv
module tb_ide_bm_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       rd_valid;
  logic [7:0] rdata;
  logic [1:0] chan_irq = '0, dma_err = '0, dma_done = '0;
  logic [1:0] dma_start, dma_dir;
  logic       host_irq;
  logic [7:0] chan_cfg;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];
  bit         done_flag = 0;

  always #10 clk = ~clk;

  ide_bm_regs dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string req);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); req_q.push_back(req);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic settle(); repeat (2) @(negedge clk); endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R13 unexpected read", rdata, 0);
      else begin
        logic [7:0] e; string r;
        e = exp_q.pop_front(); r = req_q.pop_front();
        chk(rdata === e, r, rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int i = 0; i < 16; i++) rd(4'(i), 8'h00, "R1 reset read");
    chk(host_irq === 1'b0, "R1 host_irq", host_irq, 0);
    chk(chan_cfg === 8'h0C, "R11 cfg byte", chan_cfg, 8'h0C);

    // R9 command
    wr(4'd0, 8'hFF);
    chk(dma_start === 2'b01 && dma_dir === 2'b01, "R9 start/dir", {dma_start, dma_dir}, 4'b0101);
    rd(4'd0, 8'h09, "R9 cmd mask");
    rd(4'd2, 8'h01, "R9 active set");
    rd(4'd8, 8'h00, "R2 ch1 cmd untouched");
    wr(4'd2, 8'h00);
    rd(4'd2, 8'h01, "R8 bit0 held on write");
    wr(4'd0, 8'h08);
    rd(4'd2, 8'h00, "R9 active clear");

    // R12 / R8 status on channel 1
    @(negedge clk); dma_err = 2'b10; dma_done = 2'b10;
    @(negedge clk); dma_err = 2'b00; dma_done = 2'b00;
    rd(4'd10, 8'h06, "R12 events set");
    wr(4'd10, 8'hFF);
    rd(4'd10, 8'h60, "R8 w1c and writable");
    @(negedge clk); dma_err = 2'b10; dma_done = 2'b10;
    @(negedge clk); dma_err = 2'b00; dma_done = 2'b00;
    wr(4'd10, 8'h04);
    rd(4'd10, 8'h02, "R8 partial clear");
    rd(4'd2, 8'h00, "R2 ch0 status untouched");
    // set wins over clear in same cycle
    @(negedge clk); wr_en = 1'b1; addr = 4'd10; wdata = 8'h02; dma_err = 2'b10;
    @(negedge clk); wr_en = 1'b0; dma_err = 2'b00;
    rd(4'd10, 8'h02, "R12 set over clear");

    // R3 timing
    wr(4'd3, 8'hA5);
    wr(4'd11, 8'h3C);
    rd(4'd3, 8'hA5, "R3 ch0 timing");
    rd(4'd11, 8'h3C, "R3 ch1 timing");

    // R10 address
    wr(4'd12, 8'hFF); wr(4'd13, 8'h12); wr(4'd14, 8'h34); wr(4'd15, 8'h56);
    rd(4'd12, 8'hFC, "R10 low bits zero");
    rd(4'd13, 8'h12, "R10 byte1");
    rd(4'd15, 8'h56, "R10 byte3");
    rd(4'd4, 8'h00, "R2 ch0 addr untouched");

    // R4..R7 mode and interrupt
    wr(4'd1, 8'hFF);
    rd(4'd9, 8'h30, "R5 only block bits");
    @(negedge clk); chan_irq = 2'b01;
    @(negedge clk);
    chk(host_irq === 1'b0, "R7 blocked ch0", host_irq, 0);
    rd(4'd1, 8'h34, "R6 pend set");
    wr(4'd9, 8'h00);
    chk(host_irq === 1'b1, "R7 unblocked ch0", host_irq, 1);
    rd(4'd9, 8'h04, "R5 pend kept on write");
    @(negedge clk); chan_irq = 2'b00;
    @(negedge clk);
    chk(host_irq === 1'b0, "R6 pend clear", host_irq, 0);
    @(negedge clk); chan_irq = 2'b10;
    @(negedge clk);
    chk(host_irq === 1'b1, "R7 ch1 raise", host_irq, 1);
    wr(4'd1, 8'h20);
    chk(host_irq === 1'b0, "R7 ch1 blocked", host_irq, 0);
    wr(4'd1, 8'h10);
    chk(host_irq === 1'b1, "R7 wrong block kept line", host_irq, 1);
    rd(4'd1, 8'h18, "R4 layout");

    // R1 reset mid-run
    @(negedge clk); chan_irq = 2'b00; rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk(host_irq === 1'b0, "R1 irq after reset", host_irq, 0);
    rd(4'd3, 8'h00, "R1 timing cleared");
    rd(4'd13, 8'h00, "R1 addr cleared");
    rd(4'd1, 8'h00, "R1 mode cleared");
    rd(4'd10, 8'h00, "R1 status cleared");
    settle();
    chk(exp_q.size() == 0, "R13 reads drained", exp_q.size(), 0);
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule